// File: doc/BRIEF.md
# Dual-Mask Predicated SIMT Lane Unit

This unit performs one element-wise operation (add, subtract, AND, OR or XOR) across a 128-bit vector register. The element width can be 8, 16 or 32 bits. Each element is written under two predicates at once. The first is a per-element mask that is packed at the element width. The second is a thread mask with one bit per 32-bit lane, and that granularity never changes with the element width. An element whose two predicate bits are not both set keeps the old destination contents, which the unit receives on an input. A converged multi-thread engine issues the operation with a start strobe. It receives the merged result one cycle later, together with a done pulse.

In the same cycle the unit reduces a chosen mask to three branch flags: none set, any set and all set. The chosen mask is either the thread mask or the valid part of the element mask. A branch unit outside this block uses these flags for uniform-branch decisions.

Top module: `simt_pred_unit`

## Requirements
- R1: While reset (rstN low) is asserted and after it is released, `result` is zero, `done` is low and all three summary flags are low until the first start.
- R2: A start sampled at a rising edge updates `result` and the flags at that edge and raises `done` for exactly one cycle. Without start, `result` and the flags hold their values and `done` is low.
- R3: `opcode` 0 adds, 1 subtracts (srcA minus srcB), 2 ANDs, 3 ORs and 4 XORs. Arithmetic wraps modulo the element width, and no carry or borrow crosses an element boundary.
- R4: `widthSel` 0 selects 8-bit elements, 1 selects 16-bit and 2 or 3 select 32-bit. Element i occupies bits i*w through i*w+w-1, and bit i of `elemMask` predicates it.
- R5: Bit j of `threadMask` predicates bits 32j through 32j+31 at every element width.
- R6: An element takes the operation result only when its `elemMask` bit and its lane's `threadMask` bit are both 1. Otherwise its bits equal the same bits of `destOld`.
- R7: Bits of `elemMask` at index 128/w and above affect neither `result` nor the flags.
- R8: Opcodes 5, 6 and 7 write no element: `result` equals `destOld`.
- R9: `sumSel` 0 summarises the 4 bits of `threadMask`. `sumSel` 1 summarises the low 128/w bits of `elemMask`. `noneSet` is 1 when no summarised bit is 1. `anySet` is its complement. `allSet` is 1 when every summarised bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe, one cycle |
| opcode | input | 3 | Operation code (R3, R8) |
| widthSel | input | 2 | Element width code (R4) |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| destOld | input | 128 | Previous destination contents |
| elemMask | input | 16 | Per-element predicate |
| threadMask | input | 4 | Per-32-bit-lane thread predicate |
| sumSel | input | 1 | Mask chosen for the summary |
| result | output | 128 | Merged destination |
| done | output | 1 | Result valid pulse |
| noneSet | output | 1 | No summarised bit set |
| anySet | output | 1 | Some summarised bit set |
| allSet | output | 1 | Every summarised bit set |

## Verification
The bench sums all-ones bytes with ones at every width. A design that lets carries leak across element boundaries then corrupts the neighbouring element. It enables a single thread lane under 8-bit elements, so a design that indexes the thread mask by element number instead of by lane writes the wrong 32-bit slice. It sets only the upper element-mask bits under 32-bit elements, where a design that fails to ignore them writes elements or reports "any". Reserved opcodes and an idle cycle after done are checked for a design that writes when it should not, or keeps `done` high.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } simt_op_e;

  typedef struct packed {
    logic capture;  // register result and flags this edge
    logic writeOk;  // opcode is one that writes elements
  } simt_ctrl_t;
endpackage

// File: rtl/simt_elem_alu.sv
module simt_elem_alu #(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import simt_pkg::*;

  always_comb begin
    case (simt_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simt_ctrl.sv
module simt_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [2:0]           opcode,
  output simt_pkg::simt_ctrl_t ctrlOut,
  output logic                 done
);
  always_comb begin
    ctrlOut.capture = start;
    ctrlOut.writeOk = (opcode <= 3'd4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  // R2: done follows start by one cycle and lasts one cycle
  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
endmodule

// File: rtl/simt_datapath.sv
module simt_datapath #(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  simt_pkg::simt_ctrl_t ctrlIn,
  input  logic [2:0]           opcode,
  input  logic [1:0]           widthSel,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [VEC_W-1:0]     destOld,
  input  logic [VEC_W/8-1:0]   elemMask,
  input  logic [VEC_W/32-1:0]  threadMask,
  input  logic                 sumSel,
  output logic [VEC_W-1:0]     result,
  output logic                 noneSet,
  output logic                 anySet,
  output logic                 allSet
);
  localparam int BYTES  = VEC_W / 8;
  localparam int HALVES = VEC_W / 16;
  localparam int LANES  = VEC_W / 32;
  localparam int MASK_W = BYTES;

  logic [VEC_W-1:0] res8, res16, res32, merged;
  logic [BYTES-1:0] byteEn;
  logic [MASK_W-1:0] validMask, selBits, selValid;

  genvar g;
  generate
    for (g = 0; g < BYTES; g++) begin : g_alu8
      simt_elem_alu #(.W(8)) u_alu (.op(opcode), .a(srcA[g*8 +: 8]),
        .b(srcB[g*8 +: 8]), .y(res8[g*8 +: 8]));
    end
    for (g = 0; g < HALVES; g++) begin : g_alu16
      simt_elem_alu #(.W(16)) u_alu (.op(opcode), .a(srcA[g*16 +: 16]),
        .b(srcB[g*16 +: 16]), .y(res16[g*16 +: 16]));
    end
    for (g = 0; g < LANES; g++) begin : g_alu32
      simt_elem_alu #(.W(32)) u_alu (.op(opcode), .a(srcA[g*32 +: 32]),
        .b(srcB[g*32 +: 32]), .y(res32[g*32 +: 32]));
    end
    for (g = 0; g < BYTES; g++) begin : g_merge
      logic elemBit;
      logic [7:0] pick;
      always_comb begin
        case (widthSel)
          2'd0: begin elemBit = elemMask[g];     pick = res8[g*8 +: 8];  end
          2'd1: begin elemBit = elemMask[g/2];   pick = res16[g*8 +: 8]; end
          default: begin elemBit = elemMask[g/4]; pick = res32[g*8 +: 8]; end
        endcase
        byteEn[g] = elemBit & threadMask[g/4] & ctrlIn.writeOk;
        merged[g*8 +: 8] = byteEn[g] ? pick : destOld[g*8 +: 8];
      end
    end
  endgenerate

  always_comb begin
    case (widthSel)
      2'd0:    validMask = {MASK_W{1'b1}};
      2'd1:    validMask = {MASK_W{1'b1}} >> (MASK_W / 2);
      default: validMask = {MASK_W{1'b1}} >> (MASK_W - LANES);
    endcase
    if (sumSel) begin
      selBits  = elemMask & validMask;
      selValid = validMask;
    end else begin
      selBits  = MASK_W'(threadMask);
      selValid = MASK_W'({LANES{1'b1}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      noneSet <= 1'b0;
      anySet  <= 1'b0;
      allSet  <= 1'b0;
    end else if (ctrlIn.capture) begin
      result  <= merged;
      noneSet <= (selBits == '0);
      anySet  <= (selBits != '0);
      allSet  <= (selBits == selValid);
    end
  end

  // R2: outputs hold when nothing was issued
  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.capture |=> $stable(result) && $stable(anySet));
  // R9: none and any are complementary once a summary was captured
  assert_none_any_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.capture |=> (noneSet != anySet));
  assert_all_implies_any_R9: assert property (@(posedge clk) disable iff (!rstN)
    allSet |-> anySet);
  // R6: with every thread lane off the destination is untouched
  assert_threads_off_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.capture && threadMask == '0) |=> (result == $past(destOld)));
endmodule

// File: rtl/simt_pred_unit.sv
module simt_pred_unit (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   opcode,
  input  logic [1:0]   widthSel,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic [127:0] destOld,
  input  logic [15:0]  elemMask,
  input  logic [3:0]   threadMask,
  input  logic         sumSel,
  output logic [127:0] result,
  output logic         done,
  output logic         noneSet,
  output logic         anySet,
  output logic         allSet
);
  simt_pkg::simt_ctrl_t ctrlBus;

  simt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .ctrlOut(ctrlBus), .done(done)
  );

  simt_datapath #(.VEC_W(128)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .opcode(opcode),
    .widthSel(widthSel), .srcA(srcA), .srcB(srcB), .destOld(destOld),
    .elemMask(elemMask), .threadMask(threadMask), .sumSel(sumSel),
    .result(result), .noneSet(noneSet), .anySet(anySet), .allSet(allSet)
  );
endmodule

// File: tb/tb_simt_pred_unit.sv
`timescale 1ns/1ps
module tb_simt_pred_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opcode = '0;
  logic [1:0] widthSel = '0;
  logic [127:0] srcA = '0, srcB = '0, destOld = '0;
  logic [15:0] elemMask = '0;
  logic [3:0] threadMask = '0;
  logic sumSel = 1'b0;
  logic [127:0] result;
  logic done, noneSet, anySet, allSet;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  simt_pred_unit dut (.*);

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  wc;
    logic [15:0] lm;
    logic [3:0]  tm;
    logic        sel;
    logic        eNone;
    logic        eAny;
    logic        eAll;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 2'd0, 16'hFFFF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1},
    '{3'd1, 2'd1, 16'h00AA, 4'h5, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd2, 2'd2, 16'h000F, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1},
    '{3'd3, 2'd0, 16'h0F0F, 4'hA, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd4, 2'd1, 16'hFF00, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd0, 2'd2, 16'hFFF0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd1, 2'd0, 16'h1234, 4'h9, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd0, 2'd3, 16'h0005, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd5, 2'd0, 16'hFFFF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  localparam logic [127:0] A0 = 128'hFF80_7FFF_0001_FFFF_8000_00FF_1234_FFFE;
  localparam logic [127:0] B0 = 128'h0180_8001_FFFF_0001_8000_FF01_4321_0003;
  localparam logic [127:0] D0 = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_5555_AAAA;

  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] wc,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] d,
      input logic [15:0] lm, input logic [3:0] tm);
    int w;
    logic [127:0] r, m, x, y, z;
    w = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    r = d;
    m = (128'd1 << w) - 128'd1;
    for (int i = 0; i < 128 / w; i++) begin
      if (lm[i] && tm[(i * w) / 32] && op <= 3'd4) begin
        x = (a >> (i * w)) & m;
        y = (b >> (i * w)) & m;
        case (op)
          3'd0: z = x + y;
          3'd1: z = x - y;
          3'd2: z = x & y;
          3'd3: z = x | y;
          default: z = x ^ y;
        endcase
        z = z & m;
        r = (r & ~(m << (i * w))) | (z << (i * w));
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] wc,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] d,
      input logic [15:0] lm, input logic [3:0] tm, input logic sel);
    @(negedge clk);
    opcode = op; widthSel = wc; srcA = a; srcB = b; destOld = d;
    elemMask = lm; threadMask = tm; sumSel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] exp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result == '0 && !done && !noneSet && !anySet && !allSet, "R1 reset",
          {result[123:0], done, noneSet, anySet, allSet}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == '0 && !done, "R1 after release", result, 128'd0);

    // Table walk: R3 R4 R5 R6 R8 R9
    for (int k = 0; k < NVEC; k++) begin
      logic [127:0] a, b, d;
      a = A0 ^ {16{8'(k)}};
      b = B0 ^ {16{8'(k * 3)}};
      d = D0 ^ {16{8'(k * 5)}};
      exp = model(VECS[k].op, VECS[k].wc, a, b, d, VECS[k].lm, VECS[k].tm);
      issue(VECS[k].op, VECS[k].wc, a, b, d, VECS[k].lm, VECS[k].tm, VECS[k].sel);
      check(done, $sformatf("R2 done vec %0d", k), 128'(done), 128'd1);
      check(result == exp, $sformatf("R3 R6 R8 result vec %0d", k), result, exp);
      check({noneSet, anySet, allSet} == {VECS[k].eNone, VECS[k].eAny, VECS[k].eAll},
            $sformatf("R9 flags vec %0d", k), 128'({noneSet, anySet, allSet}),
            128'({VECS[k].eNone, VECS[k].eAny, VECS[k].eAll}));
    end

    // R2: idle cycle, inputs change, outputs hold, done low
    exp = result;
    @(negedge clk);
    srcA = ~srcA; destOld = ~destOld; threadMask = 4'h0; sumSel = 1'b0;
    @(negedge clk);
    check(!done && result == exp, "R2 hold without start", result, exp);
    check(anySet == 1'b1, "R2 flags hold", 128'(anySet), 128'd1);

    // R3: carry isolation, all-ones plus ones at each width
    issue(3'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, '0, 16'hFFFF, 4'hF, 1'b0);
    check(result == '0, "R3 add 8-bit no carry out", result, 128'd0);
    issue(3'd0, 2'd1, {16{8'hFF}}, {16{8'h01}}, '0, 16'hFFFF, 4'hF, 1'b0);
    check(result == {8{16'h0100}}, "R3 add 16-bit", result, {8{16'h0100}});
    issue(3'd0, 2'd2, {16{8'hFF}}, {16{8'h01}}, '0, 16'hFFFF, 4'hF, 1'b0);
    check(result == {4{32'h0101_0100}}, "R3 add 32-bit", result, {4{32'h0101_0100}});
    issue(3'd1, 2'd0, '0, {16{8'h01}}, '0, 16'hFFFF, 4'hF, 1'b0);
    check(result == {16{8'hFF}}, "R3 sub 8-bit borrow", result, {16{8'hFF}});

    // R5: single thread lane under 8-bit elements writes bits 63:32 only
    issue(3'd3, 2'd0, '0, {16{8'hFF}}, '0, 16'hFFFF, 4'h2, 1'b0);
    exp = {64'd0, 32'hFFFF_FFFF, 32'd0};
    check(result == exp, "R5 thread lane 1", result, exp);
    // R4: element 1 of 16-bit width is bits 31:16
    issue(3'd3, 2'd1, '0, {16{8'hFF}}, '0, 16'h0002, 4'hF, 1'b1);
    exp = {96'd0, 16'hFFFF, 16'd0};
    check(result == exp, "R4 16-bit element 1", result, exp);
    check(!allSet && anySet, "R9 partial 16-bit", 128'({anySet, allSet}), 128'd2);

    // R7: upper element-mask bits ignored at 32-bit width
    issue(3'd3, 2'd2, '0, {16{8'hFF}}, D0, 16'hFFF0, 4'hF, 1'b1);
    check(result == D0, "R7 upper mask result", result, D0);
    check(noneSet && !anySet && !allSet, "R7 upper mask flags",
          128'({noneSet, anySet, allSet}), 128'd4);
    // R8: reserved opcode 7
    issue(3'd7, 2'd0, A0, B0, D0, 16'hFFFF, 4'hF, 1'b0);
    check(result == D0, "R8 opcode 7", result, D0);
    // R6: element mask set but thread off
    issue(3'd0, 2'd0, A0, B0, D0, 16'hFFFF, 4'h0, 1'b0);
    check(result == D0 && noneSet, "R6 thread mask clear", result, D0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule